// File: doc/BRIEF.md
# Parallel ATA PIO Cycle Sequencer

This block runs one host-side parallel ATA bus cycle at a time. A cycle is either a register-file access or a data-port access. On a request strobe it captures the direction, the chip-select pair, the 3-bit device address and the write data. It then steps through three timed phases: address setup, read or write strobe, and end of cycle. It drives the chip selects, the address lines, the two strobes and the data output enable on the bus.

Every phase length is a clock count taken from packed timing words that a timing calculator supplies. Register-file accesses and data-port accesses take their strobe and end-of-cycle counts from separate words.

When flow control is enabled, a device can hold IORDY low to stretch the strobe. A watchdog ends the cycle if IORDY stays low too long. Read data is captured when the read strobe is released. Completion is reported with a one-clock done pulse.

Top module: `pata_pio_seq`

## Requirements
- R1: After reset, and whenever no cycle is running, dior_no, diow_no and both cs_no bits are high, and dd_oe_o, done_o and timeout_o are low.
- R2: For one cycle, cs_no equals the inverse of cs_sel_i and da_o equals da_i, both captured at the request. They are valid for the setup count before a strobe falls and stay stable until done. The setup count is pio_tim0_i[SW-1:0].
- R3: With flow control off, the strobe stays low for exactly the strobe count. A low IORDY then has no effect.
- R4: After the strobe rises, the chip selects stay valid for max(end count, hold count) clocks. done_o is then high for one clock, the bus is idle, and a new request is accepted in that same clock.
- R5: On a write, dd_oe_o is high and dd_o carries the write data from the first setup clock until hold-count clocks after diow_no rises. The hold count is pio_tim0_i[2*SW+CW-1:SW+CW]. On a read, dd_oe_o stays low.
- R6: On a read, rdata_o takes the value of dd_i at the clock edge where dior_no rises. The value is held and is valid while done_o is high.
- R7: A data-port access is cs_sel_i = 2'b01 with da_i = 0. It uses strobe count pio_tim1_i[CW-1:0] and end count pio_tim0_i[SW+CW-1:SW]. Every other access uses strobe count reg_tim_i[2*CW-1:CW] and end count reg_tim_i[CW-1:0].
- R8: With iordy_en_i high, suppose IORDY rises during strobe clock k. The strobe then lasts max(strobe count, k + SYNC_STAGES) clocks.
- R9: With iordy_en_i high, suppose IORDY stays low for TO_CYC strobe clocks. The strobe rises after TO_CYC clocks, timeout_o is high together with done_o, and rdata_o is left unchanged.
- R10: A request made while a cycle is running is ignored.
- R11: A read asserts only dior_no and a write asserts only diow_no. The two strobes are never low together.
- R12: Any count of zero is treated as one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a cycle (taken only when idle) |
| wr_i | input | 1 | 1 = write, 0 = read |
| cs_sel_i | input | 2 | Chip selects, active high (bit 0 = first select) |
| da_i | input | 3 | Device address |
| wdata_i | input | DW | Write data |
| iordy_en_i | input | 1 | Enable strobe stretching by IORDY |
| reg_tim_i | input | 2*CW | Register word: {strobe, end} |
| pio_tim0_i | input | 2*SW+CW | PIO word 0: {hold, end, setup} |
| pio_tim1_i | input | CW | PIO word 1: strobe |
| dd_i | input | DW | Data bus input |
| iordy_i | input | 1 | Device ready, asynchronous |
| cs_no | output | 2 | Chip selects, active low |
| da_o | output | 3 | Device address lines |
| dior_no | output | 1 | Read strobe, active low |
| diow_no | output | 1 | Write strobe, active low |
| dd_o | output | DW | Data bus output |
| dd_oe_o | output | 1 | Data bus output enable |
| rdata_o | output | DW | Captured read data |
| done_o | output | 1 | One-clock cycle-complete pulse |
| timeout_o | output | 1 | IORDY timeout, high with done_o |

## Verification
The bench builds the block with TO_CYC = 64, CW = 8, SW = 4 and two IORDY synchronizer stages. The small TO_CYC brings the timeout abort within a few dozen clocks, so a cycle whose strobe lasts exactly TO_CYC clocks can be measured. With narrow count fields, random setup, strobe, end and hold counts cover the zero case, the case where hold exceeds end, and the crossover between register and data-port timing sets.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_STRB  = 2'd2,
    PH_END   = 2'd3
  } phase_e;
endpackage

// File: rtl/pata_tim_sel.sv
module pata_tim_sel #(
  parameter int CW = 8,
  parameter int SW = 4
) (
  input  logic                 data_port_i,
  input  logic [2*CW-1:0]      reg_tim_i,
  input  logic [2*SW+CW-1:0]   pio_tim0_i,
  input  logic [CW-1:0]        pio_tim1_i,
  output logic [CW-1:0]        setup_len_o,
  output logic [CW-1:0]        strb_len_o,
  output logic [CW-1:0]        end_len_o,
  output logic [CW-1:0]        hold_len_o
);
  localparam int P0W = 2*SW + CW;

  function automatic logic [CW-1:0] min_one(logic [CW-1:0] v);
    return (v == '0) ? CW'(1) : v;
  endfunction

  logic [SW-1:0] su_raw, hd_raw;
  logic [CW-1:0] pio_end_raw, reg_end_raw, reg_strb_raw;
  logic [CW-1:0] end_eff;

  assign su_raw       = pio_tim0_i[SW-1:0];
  assign pio_end_raw  = pio_tim0_i[SW+CW-1:SW];
  assign hd_raw       = pio_tim0_i[P0W-1:SW+CW];
  assign reg_end_raw  = reg_tim_i[CW-1:0];
  assign reg_strb_raw = reg_tim_i[2*CW-1:CW];

  assign setup_len_o = min_one(CW'(su_raw));
  assign hold_len_o  = min_one(CW'(hd_raw));
  assign strb_len_o  = min_one(data_port_i ? pio_tim1_i : reg_strb_raw);
  assign end_eff     = min_one(data_port_i ? pio_end_raw : reg_end_raw);
  // end phase must also cover the write-data hold
  assign end_len_o   = (hold_len_o > end_eff) ? hold_len_o : end_eff;
endmodule

// File: rtl/pata_iordy_sync.sv
module pata_iordy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic iordy_i,
  output logic iordy_o
);
  generate
    if (STAGES <= 1) begin : g_one
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b1;
        else         q <= iordy_i;
      end
      assign iordy_o = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '1;
        else         q <= {q[STAGES-2:0], iordy_i};
      end
      assign iordy_o = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pata_cycle_fsm.sv
module pata_cycle_fsm
  import pata_pio_pkg::*;
#(
  parameter int DW     = 16,
  parameter int CW     = 8,
  parameter int TO_CYC = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [1:0]    cs_sel_i,
  input  logic [2:0]    da_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          iordy_en_i,
  input  logic [DW-1:0] dd_i,
  input  logic          iordy_s_i,
  input  logic [CW-1:0] setup_len_i,
  input  logic [CW-1:0] strb_len_i,
  input  logic [CW-1:0] end_len_i,
  input  logic [CW-1:0] hold_len_i,
  output logic          data_port_o,
  output logic [1:0]    cs_no,
  output logic [2:0]    da_o,
  output logic          dior_no,
  output logic          diow_no,
  output logic [DW-1:0] dd_o,
  output logic          dd_oe_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic          timeout_o
);
  localparam int TW = $clog2(TO_CYC + 1);
  localparam logic [TW-1:0] WT_LAST = TW'(TO_CYC - 1);

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] wt_q;
  logic          wr_q, ien_q, to_hit_q, done_q, to_q;
  logic [1:0]    cs_q;
  logic [2:0]    da_q;
  logic [DW-1:0] wd_q, rd_q;
  logic          stall, active;

  assign stall  = ien_q && !iordy_s_i;
  assign active = (ph_q != PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      wt_q     <= '0;
      wr_q     <= 1'b0;
      ien_q    <= 1'b0;
      to_hit_q <= 1'b0;
      done_q   <= 1'b0;
      to_q     <= 1'b0;
      cs_q     <= '0;
      da_q     <= '0;
      wd_q     <= '0;
      rd_q     <= '0;
    end else begin
      done_q <= 1'b0;
      to_q   <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (req_i) begin
          wr_q     <= wr_i;
          ien_q    <= iordy_en_i;
          cs_q     <= cs_sel_i;
          da_q     <= da_i;
          wd_q     <= wdata_i;
          to_hit_q <= 1'b0;
          cnt_q    <= CW'(1);
          ph_q     <= PH_SETUP;
        end
        PH_SETUP: begin
          if (cnt_q >= setup_len_i) begin
            ph_q  <= PH_STRB;
            cnt_q <= CW'(1);
            wt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        PH_STRB: begin
          if (stall && wt_q == WT_LAST) begin
            ph_q     <= PH_END;
            cnt_q    <= CW'(1);
            to_hit_q <= 1'b1;
          end else if (cnt_q >= strb_len_i && !stall) begin
            ph_q  <= PH_END;
            cnt_q <= CW'(1);
            if (!wr_q) rd_q <= dd_i;
          end else begin
            if (cnt_q < strb_len_i) cnt_q <= cnt_q + CW'(1);
            wt_q <= stall ? wt_q + TW'(1) : '0;
          end
        end
        PH_END: begin
          if (cnt_q >= end_len_i) begin
            ph_q   <= PH_IDLE;
            done_q <= 1'b1;
            to_q   <= to_hit_q;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign data_port_o = (cs_q == 2'b01) && (da_q == 3'd0);
  assign cs_no       = active ? ~cs_q : 2'b11;
  assign da_o        = active ? da_q : 3'd0;
  assign dior_no     = !(ph_q == PH_STRB && !wr_q);
  assign diow_no     = !(ph_q == PH_STRB && wr_q);
  assign dd_o        = wd_q;
  assign dd_oe_o     = wr_q && (ph_q == PH_SETUP || ph_q == PH_STRB ||
                                (ph_q == PH_END && cnt_q <= hold_len_i));
  assign rdata_o     = rd_q;
  assign done_o      = done_q;
  assign timeout_o   = to_q;

  assert_one_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dior_no && !diow_no));
  assert_addr_before_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dior_no) || $fell(diow_no)) |-> ($past(cs_no) != 2'b11));
  assert_addr_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && $past(active) && !$past(done_o)) |-> ($stable(cs_no) && $stable(da_o)));
  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_timeout_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);
  assert_no_drive_on_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dior_no |-> !dd_oe_o);
  assert_idle_bus_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no == 2'b11 && dior_no && diow_no && !dd_oe_o));
endmodule

// File: rtl/pata_pio_seq.sv
module pata_pio_seq #(
  parameter int DW          = 16,
  parameter int CW          = 8,
  parameter int SW          = 4,
  parameter int TO_CYC      = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 wr_i,
  input  logic [1:0]           cs_sel_i,
  input  logic [2:0]           da_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 iordy_en_i,
  input  logic [2*CW-1:0]      reg_tim_i,
  input  logic [2*SW+CW-1:0]   pio_tim0_i,
  input  logic [CW-1:0]        pio_tim1_i,
  input  logic [DW-1:0]        dd_i,
  input  logic                 iordy_i,
  output logic [1:0]           cs_no,
  output logic [2:0]           da_o,
  output logic                 dior_no,
  output logic                 diow_no,
  output logic [DW-1:0]        dd_o,
  output logic                 dd_oe_o,
  output logic [DW-1:0]        rdata_o,
  output logic                 done_o,
  output logic                 timeout_o
);
  logic          iordy_s, data_port;
  logic [CW-1:0] setup_len, strb_len, end_len, hold_len;

  pata_iordy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .iordy_i(iordy_i), .iordy_o(iordy_s)
  );

  pata_tim_sel #(.CW(CW), .SW(SW)) u_tim (
    .data_port_i(data_port), .reg_tim_i(reg_tim_i),
    .pio_tim0_i(pio_tim0_i), .pio_tim1_i(pio_tim1_i),
    .setup_len_o(setup_len), .strb_len_o(strb_len),
    .end_len_o(end_len), .hold_len_o(hold_len)
  );

  pata_cycle_fsm #(.DW(DW), .CW(CW), .TO_CYC(TO_CYC)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i),
    .cs_sel_i(cs_sel_i), .da_i(da_i), .wdata_i(wdata_i),
    .iordy_en_i(iordy_en_i), .dd_i(dd_i), .iordy_s_i(iordy_s),
    .setup_len_i(setup_len), .strb_len_i(strb_len),
    .end_len_i(end_len), .hold_len_i(hold_len),
    .data_port_o(data_port), .cs_no(cs_no), .da_o(da_o),
    .dior_no(dior_no), .diow_no(diow_no), .dd_o(dd_o), .dd_oe_o(dd_oe_o),
    .rdata_o(rdata_o), .done_o(done_o), .timeout_o(timeout_o)
  );
endmodule

// File: tb/pata_pio_seq_bench.sv
module pata_pio_seq_bench;
  localparam int DW = 16, CW = 8, SW = 4, TO_CYC = 64, SYNC = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, wr_i = 1'b0, iordy_en_i = 1'b0, iordy_i = 1'b1;
  logic [1:0] cs_sel_i = '0;
  logic [2:0] da_i = '0;
  logic [DW-1:0] wdata_i = '0, dd_i = '0;
  logic [2*CW-1:0] reg_tim_i = '0;
  logic [2*SW+CW-1:0] pio_tim0_i = '0;
  logic [CW-1:0] pio_tim1_i = '0;
  logic [1:0] cs_no;
  logic [2:0] da_o;
  logic dior_no, diow_no, dd_oe_o, done_o, timeout_o;
  logic [DW-1:0] dd_o, rdata_o;

  always #10 clk_i = ~clk_i;

  pata_pio_seq #(.DW(DW), .CW(CW), .SW(SW), .TO_CYC(TO_CYC), .SYNC_STAGES(SYNC)) u_pata_pio_seq (
    .clk_i, .rst_ni, .req_i, .wr_i, .cs_sel_i, .da_i, .wdata_i, .iordy_en_i,
    .reg_tim_i, .pio_tim0_i, .pio_tim1_i, .dd_i, .iordy_i,
    .cs_no, .da_o, .dior_no, .diow_no, .dd_o, .dd_oe_o, .rdata_o, .done_o, .timeout_o
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stimulus for one cycle
  bit t_wr, t_ien, t_to, t_busy, t_lowig;
  logic [1:0] t_cs;
  logic [2:0] t_da;
  logic [DW-1:0] t_wd, t_rd, exp_rdata;
  int t_krise, t_su, t_rs, t_re, t_ps, t_pe, t_h;

  function automatic int eff(int v); return (v == 0) ? 1 : v; endfunction
  function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction

  task automatic run_cycle();
    int s_e, e_e, h_e, su_e, str_exp, end_exp, hold_exp;
    int n_su = 0, n_st = 0, n_en = 0, n_h = 0, ph = 0, guard = 0;
    bit dp, addr_ok = 1, kind_ok = 1, drv_ok = 1;
    dp   = (t_cs == 2'b01) && (t_da == 3'd0);
    su_e = eff(t_su);
    h_e  = eff(t_h);
    s_e  = dp ? eff(t_ps) : eff(t_rs);
    e_e  = dp ? eff(t_pe) : eff(t_re);
    if (t_to) str_exp = TO_CYC;
    else if (t_ien && t_krise >= 0) str_exp = imax(s_e, t_krise + SYNC);
    else str_exp = s_e;
    end_exp  = imax(e_e, h_e);
    hold_exp = t_wr ? h_e : 0;

    @(negedge clk_i);
    reg_tim_i  = {CW'(t_rs), CW'(t_re)};
    pio_tim0_i = {SW'(t_h), CW'(t_pe), SW'(t_su)};
    pio_tim1_i = CW'(t_ps);
    iordy_i    = (t_krise >= 0 || t_to || t_lowig) ? 1'b0 : 1'b1;
    dd_i       = t_rd;
    repeat (SYNC + 1) @(negedge clk_i);
    wr_i = t_wr; cs_sel_i = t_cs; da_i = t_da; wdata_i = t_wd;
    iordy_en_i = t_ien; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    while (guard < TO_CYC + 200) begin
      if (done_o) break;
      if (t_busy && guard == 1) begin
        req_i = 1'b1; cs_sel_i = ~t_cs; da_i = ~t_da; wr_i = ~t_wr;
      end else req_i = 1'b0;
      if (cs_no != ~t_cs || da_o != t_da) addr_ok = 0;
      if (!dior_no || !diow_no) begin
        if (t_wr ? !(dior_no && !diow_no) : !(!dior_no && diow_no)) kind_ok = 0;
      end
      if (t_wr && ph < 2 && !(dd_oe_o && dd_o == t_wd)) drv_ok = 0;
      if (!t_wr && dd_oe_o) drv_ok = 0;
      if (ph == 0) begin
        if (!dior_no || !diow_no) begin ph = 1; n_st++; end else n_su++;
      end else if (ph == 1) begin
        if (!dior_no || !diow_no) n_st++;
        else begin ph = 2; n_en++; if (dd_oe_o) n_h++; end
      end else begin
        n_en++; if (dd_oe_o) n_h++;
      end
      if (ph == 1 && t_krise >= 0 && n_st == t_krise) iordy_i = 1'b1;
      @(negedge clk_i);
      guard++;
    end
    req_i = 1'b0;
    chk(done_o === 1'b1, "R4 done seen", done_o, 1);
    chk(n_su == su_e, "R2 setup clocks", n_su, su_e);
    chk(n_st == str_exp, t_to ? "R9 strobe on timeout" :
        (t_ien && t_krise >= 0) ? "R8 strobe with IORDY wait" :
        dp ? "R7/R3 data-port strobe" : "R7/R3 register strobe", n_st, str_exp);
    chk(n_en == end_exp, dp ? "R7/R4 data-port end" : "R7/R4 register end", n_en, end_exp);
    chk(n_h == hold_exp, "R5 write hold clocks", n_h, hold_exp);
    chk(addr_ok, "R2 address/select valid and stable", addr_ok, 1);
    chk(kind_ok, "R11 strobe kind", kind_ok, 1);
    chk(drv_ok, "R5 data drive", drv_ok, 1);
    chk(timeout_o == t_to, "R9 timeout flag", timeout_o, t_to);
    if (!t_wr && !t_to) exp_rdata = t_rd;
    chk(rdata_o == exp_rdata, t_to ? "R9 read data kept" : "R6 read data", rdata_o, exp_rdata);
    @(negedge clk_i);
    chk(!done_o && cs_no == 2'b11 && dior_no && diow_no,
        t_busy ? "R10 busy request ignored" : "R4 idle after done", cs_no, 3);
    iordy_i = 1'b1;
  endtask

  task automatic set_defaults();
    t_wr = 0; t_ien = 0; t_to = 0; t_busy = 0; t_lowig = 0; t_krise = -1;
    t_cs = 2'b01; t_da = 3'd1; t_wd = 16'h1234; t_rd = 16'hA5C3;
    t_su = 2; t_rs = 4; t_re = 3; t_ps = 5; t_pe = 2; t_h = 1;
  endtask

  initial begin
    int seed_init;
    seed_init = $urandom(32'd4711);
    exp_rdata = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(cs_no == 2'b11 && dior_no && diow_no && !dd_oe_o && !done_o && !timeout_o,
        "R1 reset idle", {cs_no, dior_no, diow_no}, 15);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cs_no == 2'b11 && dior_no && diow_no && !dd_oe_o, "R1 idle after reset", cs_no, 3);

    // R7 register vs data port with distinct counts
    set_defaults(); t_cs = 2'b01; t_da = 3'd0; t_rs = 2; t_re = 1; t_ps = 7; t_pe = 6; run_cycle();
    set_defaults(); t_cs = 2'b01; t_da = 3'd7; t_rs = 2; t_re = 1; t_ps = 7; t_pe = 6; run_cycle();
    set_defaults(); t_cs = 2'b10; t_da = 3'd6; t_wr = 1; t_rs = 6; t_re = 2; run_cycle();
    // R12 all counts zero
    set_defaults(); t_su = 0; t_rs = 0; t_re = 0; t_ps = 0; t_pe = 0; t_h = 0; t_wr = 1; run_cycle();
    set_defaults(); t_su = 0; t_rs = 0; t_re = 0; t_h = 0; run_cycle();
    // R5 hold longer than end
    set_defaults(); t_wr = 1; t_h = 5; t_re = 1; t_wd = 16'hBEEF; run_cycle();
    // R3 IORDY low ignored when disabled
    set_defaults(); t_lowig = 1; t_ien = 0; run_cycle();
    // R8 IORDY stretch
    set_defaults(); t_ien = 1; t_krise = 6; t_rd = 16'h0F0F; run_cycle();
    set_defaults(); t_ien = 1; t_krise = 1; t_rs = 8; run_cycle();
    // R9 timeout on read and write
    set_defaults(); t_ien = 1; t_to = 1; t_rd = 16'hDEAD; run_cycle();
    set_defaults(); t_ien = 1; t_to = 1; t_wr = 1; run_cycle();
    // R10 request while busy
    set_defaults(); t_busy = 1; t_su = 1; t_rs = 1; t_re = 1; t_h = 1; run_cycle();
    set_defaults(); t_busy = 1; t_wr = 1; run_cycle();

    // random mix
    for (int i = 0; i < 60; i++) begin
      set_defaults();
      t_wr  = $urandom_range(0, 1);
      t_cs  = 2'($urandom_range(1, 3));
      t_da  = 3'($urandom_range(0, 1) ? 0 : $urandom_range(0, 7));
      t_wd  = 16'($urandom);
      t_rd  = 16'($urandom);
      t_su  = $urandom_range(0, 5);
      t_rs  = $urandom_range(0, 9);
      t_re  = $urandom_range(0, 9);
      t_ps  = $urandom_range(0, 9);
      t_pe  = $urandom_range(0, 9);
      t_h   = $urandom_range(0, 5);
      t_ien = $urandom_range(0, 1);
      if (t_ien && $urandom_range(0, 2) == 0) t_krise = $urandom_range(1, 10);
      if (!t_ien) t_lowig = $urandom_range(0, 1);
      t_busy = ($urandom_range(0, 3) == 0);
      run_cycle();
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule